// File: doc/BRIEF.md
# Accumulator ALU with Bus Drive and Magnitude Compare

This block is the arithmetic core of a small bus-oriented processor. Two operand registers, the accumulator and the B register, each capture the shared 8-bit bus when their load strobe is high. A 3-bit operation field from the control word is decoded into a one-hot select. That select picks one of six results: sum, difference, bitwise AND, OR, XOR, or the complement of the accumulator.

The block drives the shared bus only through enables. The ALU result goes out under one enable and the raw accumulator under another. The bus is modelled as a data word together with a valid flag (`bus_drive`) that an external bus merge consumes.

A 3-bit magnitude flag word compares the two held operands at all times. The control sequencer uses it as part of its next-step address. If both drive enables are raised together, the block flags a conflict and drives nothing.

Top module: `bus_alu_unit`

## Requirements
- R1: A synchronous active-low reset clears the accumulator and the B register to zero.
- R2: On a rising clock edge, the accumulator captures `bus_in` when `load_acc` is high and the B register captures `bus_in` when `load_b` is high. With its strobe low, a register keeps its value whatever `bus_in` carries.
- R3: `op_sel` codes select the ALU result as follows. Code 0 gives A+B modulo 256. Code 1 gives A-B modulo 256. Code 2 gives A AND B. Code 3 gives A OR B. Code 4 gives NOT A. Code 5 gives A XOR B. Codes 6 and 7 give zero.
- R4: With `alu_oe` high and `acc_oe` low, `bus_out` equals the ALU result in the same cycle and `bus_drive` is 1.
- R5: With `acc_oe` high and `alu_oe` low, `bus_out` equals the accumulator and `bus_drive` is 1.
- R6: With both enables low, `bus_drive` is 0 and `bus_out` is 0.
- R7: With both enables high, `drive_conflict` is 1, `bus_drive` is 0 and `bus_out` is 0. Otherwise `drive_conflict` is 0.
- R8: `cmp_flags` has bit 2 set for A greater than B, bit 1 set for A equal to B and bit 0 set for A less than B. Comparison is unsigned on the held register values, and exactly one bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 8 | Current value of the shared bus |
| load_acc | input | 1 | Accumulator capture strobe |
| load_b | input | 1 | B register capture strobe |
| op_sel | input | 3 | Operation field of the control word |
| alu_oe | input | 1 | Drive ALU result onto the bus |
| acc_oe | input | 1 | Drive accumulator onto the bus |
| bus_out | output | 8 | Data this block places on the bus |
| bus_drive | output | 1 | This block is driving the bus |
| drive_conflict | output | 1 | Both drive enables raised together |
| cmp_flags | output | 3 | {greater, equal, less} for A versus B |

## Verification
The hardest state to reach from the ports is the drive conflict. No well-formed control word raises both enables, so the bench forces that illegal pair directly. It checks that the output falls silent and that the conflict flag rises, and it does this with operands loaded whose ALU result and accumulator are both nonzero. Register hold behaviour is only visible through the bus, so the bench reads the accumulator back through its own enable after toggling `bus_in` with both strobes low.

// File: rtl/alu_pkg.sv
// Shared operation codes for the bus ALU.
// Assumes a 3-bit operation field; codes above OP_XOR are reserved.
package alu_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_OPS = 6;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_NOT = 3'd4,
        OP_XOR = 3'd5
    } alu_op_e;
endpackage

// File: rtl/operand_reg.sv
// Operand register: captures its input on a load strobe, otherwise holds.
// Assumes synchronous active-low reset to zero.
module operand_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture or hold the operand value.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/alu_op_decoder.sv
// Decodes the operation field into a one-hot lane select.
// Assumes codes at or above NUM_OPS select no lane (zero result).
module alu_op_decoder #(
    parameter int SEL_W   = 3,
    parameter int NUM_OPS = 6
) (
    input  logic [SEL_W-1:0]   op_sel,
    output logic [NUM_OPS-1:0] op_hot
);
    // Raise exactly one lane for a legal code, none otherwise.
    always_comb begin
        op_hot = '0;
        for (int i = 0; i < NUM_OPS; i++)
            if (int'(op_sel) == i) op_hot[i] = 1'b1;
    end
endmodule

// File: rtl/alu_datapath.sv
// Computes all operation lanes in parallel and merges the selected one.
// Assumes op_hot is one-hot or zero; arithmetic wraps at 2**W.
module alu_datapath
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic [NUM_OPS-1:0] op_hot,
    output logic [W-1:0]       result
);
    logic [W-1:0] lanes [NUM_OPS];

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
        if (g == int'(OP_ADD)) begin : g_add
            assign lanes[g] = a + b;
        end else if (g == int'(OP_SUB)) begin : g_sub
            assign lanes[g] = a - b;
        end else if (g == int'(OP_AND)) begin : g_and
            assign lanes[g] = a & b;
        end else if (g == int'(OP_OR)) begin : g_or
            assign lanes[g] = a | b;
        end else if (g == int'(OP_NOT)) begin : g_not
            assign lanes[g] = ~a;
        end else begin : g_xor
            assign lanes[g] = a ^ b;
        end
    end

    // AND-OR merge of the lanes under the one-hot select.
    always_comb begin
        result = '0;
        for (int i = 0; i < NUM_OPS; i++)
            result = result | (lanes[i] & {W{op_hot[i]}});
    end
endmodule

// File: rtl/magnitude_cmp.sv
// Unsigned magnitude comparator producing {greater, equal, less}.
// Assumes both operands are unsigned W-bit values.
module magnitude_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [2:0]   flags
);
    // Encode the ordering of a against b.
    always_comb begin
        flags[2] = (a > b);
        flags[1] = (a == b);
        flags[0] = (a < b);
    end
endmodule

// File: rtl/bus_alu_unit.sv
// Accumulator/B-register ALU that drives a shared bus through enables
// and exports magnitude flags for the sequencer.
// Assumes the bus merge outside uses bus_drive as the valid of bus_out;
// raising both enables is treated as a fault and nothing is driven.
module bus_alu_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              load_acc,
    input  logic              load_b,
    input  logic [SEL_W-1:0]  op_sel,
    input  logic              alu_oe,
    input  logic              acc_oe,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drive,
    output logic              drive_conflict,
    output logic [2:0]        cmp_flags
);
    logic [DATA_W-1:0]  acc_q;
    logic [DATA_W-1:0]  b_q;
    logic [NUM_OPS-1:0] op_hot;
    logic [DATA_W-1:0]  alu_res;

    operand_reg #(.W(DATA_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .load(load_acc), .d(bus_in), .q(acc_q)
    );

    operand_reg #(.W(DATA_W)) u_breg (
        .clk(clk), .rst_n(rst_n), .load(load_b), .d(bus_in), .q(b_q)
    );

    alu_op_decoder #(.SEL_W(SEL_W), .NUM_OPS(NUM_OPS)) u_dec (
        .op_sel(op_sel), .op_hot(op_hot)
    );

    alu_datapath #(.W(DATA_W)) u_dp (
        .a(acc_q), .b(b_q), .op_hot(op_hot), .result(alu_res)
    );

    magnitude_cmp #(.W(DATA_W)) u_cmp (
        .a(acc_q), .b(b_q), .flags(cmp_flags)
    );

    // Pick the single bus driver, or none on a fault or idle cycle.
    always_comb begin
        drive_conflict = alu_oe & acc_oe;
        bus_drive      = alu_oe ^ acc_oe;
        bus_out        = '0;
        if (alu_oe && !acc_oe)      bus_out = alu_res;
        else if (acc_oe && !alu_oe) bus_out = acc_q;
    end
endmodule

// File: rtl/alu_unit_checker.sv
// Property checker for bus_alu_unit, attached by bind below.
// Assumes it sees the operand registers through the bind connections.
module alu_unit_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] bus_in,
    input logic         load_acc,
    input logic         load_b,
    input logic [2:0]   op_sel,
    input logic         alu_oe,
    input logic         acc_oe,
    input logic [W-1:0] acc_q,
    input logic [W-1:0] b_q,
    input logic [W-1:0] bus_out,
    input logic         bus_drive,
    input logic         drive_conflict,
    input logic [2:0]   cmp_flags
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && b_q == '0));

    a_r2_acc_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_acc |=> acc_q == $past(bus_in));

    a_r2_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_b |=> $stable(b_q));

    a_r3_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_oe && !acc_oe && op_sel == 3'd0) |-> bus_out == W'(acc_q + b_q));

    a_r5_acc_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_oe && !alu_oe) |-> (bus_drive && bus_out == acc_q));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_oe && !alu_oe) |-> (!bus_drive && bus_out == '0));

    a_r7_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_oe && alu_oe) |-> (drive_conflict && !bus_drive && bus_out == '0));

    a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmp_flags) == 1);
endmodule

bind bus_alu_unit alu_unit_checker #(.W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .load_acc(load_acc),
    .load_b(load_b), .op_sel(op_sel), .alu_oe(alu_oe), .acc_oe(acc_oe),
    .acc_q(acc_q), .b_q(b_q), .bus_out(bus_out), .bus_drive(bus_drive),
    .drive_conflict(drive_conflict), .cmp_flags(cmp_flags)
);

// File: tb/test_bus_alu_unit.sv
module test_bus_alu_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = '0;
    logic       load_acc = 1'b0;
    logic       load_b = 1'b0;
    logic [2:0] op_sel = '0;
    logic       alu_oe = 1'b0;
    logic       acc_oe = 1'b0;
    logic [7:0] bus_out;
    logic       bus_drive;
    logic       drive_conflict;
    logic [2:0] cmp_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_alu_unit i_bus_alu_unit (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .load_acc(load_acc),
        .load_b(load_b), .op_sel(op_sel), .alu_oe(alu_oe), .acc_oe(acc_oe),
        .bus_out(bus_out), .bus_drive(bus_drive),
        .drive_conflict(drive_conflict), .cmp_flags(cmp_flags)
    );

    // {a, b, op, expected result, expected flags {gt,eq,lt}}
    localparam int NV = 12;
    localparam logic [29:0] VEC [NV] = '{
        {8'h12, 8'h34, 3'd0, 8'h46, 3'b001},
        {8'hF0, 8'h20, 3'd0, 8'h10, 3'b100},
        {8'h05, 8'h07, 3'd1, 8'hFE, 3'b001},
        {8'h50, 8'h30, 3'd1, 8'h20, 3'b100},
        {8'hCC, 8'hAA, 3'd2, 8'h88, 3'b100},
        {8'hCC, 8'hAA, 3'd3, 8'hEE, 3'b100},
        {8'h3C, 8'h99, 3'd4, 8'hC3, 3'b001},
        {8'h3C, 8'h3C, 3'd5, 8'h00, 3'b010},
        {8'hFF, 8'h0F, 3'd5, 8'hF0, 3'b100},
        {8'h77, 8'h77, 3'd6, 8'h00, 3'b010},
        {8'h80, 8'h7F, 3'd7, 8'h00, 3'b100},
        {8'h00, 8'hFF, 3'd1, 8'h01, 3'b001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_pair(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk); bus_in = a; load_acc = 1'b1; load_b = 1'b0;
        @(negedge clk); bus_in = b; load_acc = 1'b0; load_b = 1'b1;
        @(negedge clk); load_b = 1'b0; bus_in = 8'h5A;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state seen through the accumulator drive and the flags
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        acc_oe = 1'b1; #1;
        check("R1 acc after reset", {24'h0, bus_out}, 32'h0);
        check("R8 flags after reset", {29'h0, cmp_flags}, 32'h2);
        check("R6 R7 no conflict single drive", {30'h0, bus_drive, drive_conflict}, 32'h2);
        acc_oe = 1'b0;

        // R3 R4 R8: vector table
        for (int i = 0; i < NV; i++) begin
            load_pair(VEC[i][29:22], VEC[i][21:14]);
            op_sel = VEC[i][13:11]; alu_oe = 1'b1; #1;
            check("R3 R4 alu result", {24'h0, bus_out}, {24'h0, VEC[i][10:3]});
            check("R4 bus_drive", {31'h0, bus_drive}, 32'h1);
            check("R8 compare flags", {29'h0, cmp_flags}, {29'h0, VEC[i][2:0]});
            alu_oe = 1'b0;
        end

        // R6: idle leaves the bus undriven
        #1;
        check("R6 idle bus_out", {24'h0, bus_out}, 32'h0);
        check("R6 idle bus_drive", {31'h0, bus_drive}, 32'h0);

        // R2: strobes low, bus toggles, registers hold
        load_pair(8'hA5, 8'h3B);
        bus_in = 8'hFF; @(negedge clk); bus_in = 8'h00; @(negedge clk);
        acc_oe = 1'b1; #1;
        check("R2 R5 acc holds", {24'h0, bus_out}, 32'hA5);
        acc_oe = 1'b0; op_sel = 3'd1; alu_oe = 1'b1; #1;
        check("R2 b holds (A-B)", {24'h0, bus_out}, 32'h6A);

        // R7: both enables raised with nonzero sources
        acc_oe = 1'b1; #1;
        check("R7 conflict flag", {31'h0, drive_conflict}, 32'h1);
        check("R7 no drive", {31'h0, bus_drive}, 32'h0);
        check("R7 bus_out zero", {24'h0, bus_out}, 32'h0);
        acc_oe = 1'b0; alu_oe = 1'b0;

        // R1: reset mid-run clears loaded values
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        acc_oe = 1'b1; #1;
        check("R1 acc cleared again", {24'h0, bus_out}, 32'h0);
        check("R1 R8 equal after reset", {29'h0, cmp_flags}, 32'h2);
        acc_oe = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule